// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital side of a 12-bit successive-approximation converter inside a small microcontroller. Software launches a conversion by writing a one to the start control bit. The sequencer then divides the system clock by a ratio chosen with a two-bit select field. It walks the approximation register from the most significant bit down to the least, and it settles each bit from a single comparator input. The comparator reports whether the analog input lies at or above the level that the current trial code puts on the DAC.

A conversion takes fourteen periods of the divided clock: one setup period, twelve bit periods and one transfer period. At the end of the transfer period the upper eight result bits go to a high register and the lower four bits go to a low register. In the same cycle the start bit drops back to zero, so it doubles as a "finished" indication, and a sticky interrupt flag is raised. Software can abort a running conversion by clearing the start bit. The previous result then stays in place and no interrupt is raised.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies and nothing here is subject to back-pressure.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, start_bit, irq_flag, res_hi, res_lo and dac_code are all zero.
- R2: A one on start_set while the block is idle sets start_bit at the next clock edge and clears dac_code to zero for the setup period.
- R3: clk_sel, captured at the start edge, sets the period length: 00 selects 4, 01 selects 16, 10 selects 32 and 11 selects 64 system clocks. start_bit falls exactly 14 periods after it rises.
- R4: Bit periods run from bit 11 down to bit 0. At the start of its period the trial bit is set in dac_code. At the last edge of the period the bit is kept if cmp_in is 1 and cleared if cmp_in is 0, so the final code equals the largest value whose trial the comparator accepted.
- R5: On completion, res_hi receives result bits 11..4 and res_lo receives result bits 3..0.
- R6: On the completion edge, start_bit clears and irq_flag sets in the same cycle.
- R7: irq_flag stays set until irq_clr is asserted. If completion and irq_clr coincide, the flag is set.
- R8: start_set during a running conversion has no effect on its length or its result.
- R9: res_hi and res_lo keep the previous result until the transfer period of the next conversion ends.
- R10: start_clr while running aborts at the next edge. The results are unchanged and irq_flag is not set. start_clr takes priority over a simultaneous start_set.
- R11: Changing clk_sel during a conversion does not alter the period length of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_set | input | 1 | Software writes one to the start bit |
| start_clr | input | 1 | Software writes zero to the start bit (abort) |
| clk_sel | input | 2 | Conversion clock divider select |
| irq_clr | input | 1 | Software clears the interrupt flag |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| dac_code | output | 12 | Trial code driving the DAC |
| start_bit | output | 1 | Start/busy bit, cleared by hardware at the end |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| res_hi | output | 8 | Result bits 11..4 |
| res_lo | output | 4 | Result bits 3..0 |

## Verification
The assertions assume that cmp_in is settled by each clock edge and depends only on dac_code, which holds its value through a whole period. The bench therefore models the comparator as a combinational compare of a fixed input code against dac_code. The bench changes that input code only while the block is idle. It drives start_set, start_clr, irq_clr and clk_sel only on falling edges, so the assertions see each control write for whole cycles. The same stimulus also brings out the abort, priority and ignored-write cases.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  localparam int SEL_W = 2;
  localparam int PRESC_MAX = 64;
  localparam int PRESC_CNT_W = $clog2(PRESC_MAX);
  localparam int CONV_PERIODS = 14;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_BITS  = 2'd2,
    ST_XFER  = 2'd3
  } conv_state_e;

  function automatic int presc_div(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
  import adc_sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRESC_CNT_W-1:0] cnt_q;
  logic [PRESC_CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt = PRESC_CNT_W'(presc_div(sel) - 1);
    tick     = run && (cnt_q == last_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
  import adc_sar_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             cmp_in,
  input  logic             tick,
  output logic             running,
  output logic [SEL_W-1:0] sel_q,
  output logic [RES_W-1:0] sar,
  output logic             done
);

  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  conv_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] sar_q;

  assign running = (state_q != ST_IDLE);
  assign sar     = sar_q;
  assign done    = (state_q == ST_XFER) && tick && !start_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sar_q   <= '0;
      sel_q   <= '0;
    end else if (start_clr) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_set) begin
            state_q <= ST_SETUP;
            sar_q   <= '0;
            sel_q   <= clk_sel;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state_q        <= ST_BITS;
            idx_q          <= TOP_IDX;
            sar_q[TOP_IDX] <= 1'b1;
          end
        end
        ST_BITS: begin
          if (tick) begin
            if (!cmp_in) sar_q[idx_q] <= 1'b0;
            if (idx_q == '0) begin
              state_q <= ST_XFER;
            end else begin
              idx_q               <= idx_q - 1'b1;
              sar_q[idx_q - 1'b1] <= 1'b1;
            end
          end
        end
        default: begin
          if (tick) state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int RES_W = 12,
  parameter int HI_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic                 irq_clr,
  input  logic [RES_W-1:0]     sar,
  output logic [HI_W-1:0]      res_hi,
  output logic [RES_W-HI_W-1:0] res_lo,
  output logic                 irq_flag
);

  localparam int LO_W = RES_W - HI_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
    end else if (done) begin
      res_hi <= sar[RES_W-1 -: HI_W];
      res_lo <= sar[LO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
    end else if (done) begin
      irq_flag <= 1'b1;
    end else if (irq_clr) begin
      irq_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_sar_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int HI_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_set,
  input  logic                    start_clr,
  input  logic [SEL_W-1:0]        clk_sel,
  input  logic                    irq_clr,
  input  logic                    cmp_in,
  output logic [RES_W-1:0]        dac_code,
  output logic                    start_bit,
  output logic                    irq_flag,
  output logic [HI_W-1:0]         res_hi,
  output logic [RES_W-HI_W-1:0]   res_lo
);

  logic             tick;
  logic             running;
  logic             done;
  logic [SEL_W-1:0] sel_q;

  adc_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .sel   (sel_q),
    .tick  (tick)
  );

  adc_sar_fsm #(.RES_W(RES_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_set (start_set),
    .start_clr (start_clr),
    .clk_sel   (clk_sel),
    .cmp_in    (cmp_in),
    .tick      (tick),
    .running   (running),
    .sel_q     (sel_q),
    .sar       (dac_code),
    .done      (done)
  );

  adc_result_bank #(.RES_W(RES_W), .HI_W(HI_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .irq_clr  (irq_clr),
    .sar      (dac_code),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .irq_flag (irq_flag)
  );

  assign start_bit = running;

endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk
  import adc_sar_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int HI_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_clr,
  input logic [SEL_W-1:0]      clk_sel,
  input logic                  irq_clr,
  input logic [RES_W-1:0]      dac_code,
  input logic                  start_bit,
  input logic                  irq_flag,
  input logic [HI_W-1:0]       res_hi,
  input logic [RES_W-HI_W-1:0] res_lo
);

  localparam int LEN_W = $clog2(CONV_PERIODS * PRESC_MAX + 1);

  logic [LEN_W-1:0] len_q;
  logic [SEL_W-1:0] sel_cap;
  logic [LEN_W-1:0] exp_len;

  assign exp_len = LEN_W'(CONV_PERIODS * presc_div(sel_cap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      sel_cap <= '0;
    end else begin
      len_q <= start_bit ? len_q + 1'b1 : '0;
      if (!start_bit) sel_cap <= clk_sel;
    end
  end

  assert_trial_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_bit) |-> dac_code == '0);

  assert_conv_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_bit) && !$past(start_clr) |-> len_q == exp_len);

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit |-> len_q < exp_len);

  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_bit) && !$past(start_clr) |-> irq_flag);

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $fell(start_bit));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_hi) || !$stable(res_lo) |-> $fell(start_bit));

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_bit) && $past(start_clr) |-> $stable(res_hi) && $stable(res_lo) && !$rose(irq_flag));

endmodule

bind adc_sar_seq adc_sar_seq_chk #(.RES_W(RES_W), .HI_W(HI_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_clr (start_clr),
  .clk_sel   (clk_sel),
  .irq_clr   (irq_clr),
  .dac_code  (dac_code),
  .start_bit (start_bit),
  .irq_flag  (irq_flag),
  .res_hi    (res_hi),
  .res_lo    (res_lo)
);

// File: tb/test_adc_sar_seq.sv
module test_adc_sar_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_set = 1'b0;
  logic        start_clr = 1'b0;
  logic [1:0]  clk_sel = 2'd0;
  logic        irq_clr = 1'b0;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic        start_bit;
  logic        irq_flag;
  logic [7:0]  res_hi;
  logic [3:0]  res_lo;

  logic [11:0] vin = 12'd0;
  logic [11:0] prev_res = 12'd0;
  int          n_checks = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  adc_sar_seq i_adc_sar_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_set (start_set),
    .start_clr (start_clr),
    .clk_sel   (clk_sel),
    .irq_clr   (irq_clr),
    .cmp_in    (cmp_in),
    .dac_code  (dac_code),
    .start_bit (start_bit),
    .irq_flag  (irq_flag),
    .res_hi    (res_hi),
    .res_lo    (res_lo)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 16;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic t_reset();
    check(start_bit == 1'b0, "R1 start_bit", int'(start_bit), 0);
    check(irq_flag == 1'b0, "R1 irq_flag", int'(irq_flag), 0);
    check({res_hi, res_lo} == 12'd0, "R1 result", int'({res_hi, res_lo}), 0);
    check(dac_code == 12'd0, "R1 dac_code", int'(dac_code), 0);
  endtask

  task automatic t_convert(input logic [1:0] sel, input logic [11:0] v,
                           input bit poke_start, input bit poke_sel, input bit hold_clr);
    int d;
    int n;
    d = div_of(sel);
    vin = v;
    clk_sel = sel;
    irq_clr = hold_clr;
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    check(start_bit == 1'b1, "R2 start_bit set", int'(start_bit), 1);
    check(dac_code == 12'd0, "R2 trial cleared", int'(dac_code), 0);
    n = 0;
    while (start_bit) begin
      start_set = (poke_start && n == 2 * d);
      if (poke_sel && n == 3 * d) clk_sel = ~sel;
      @(negedge clk);
      n++;
      if (n == d)
        check(dac_code == 12'h800, "R4 msb trial", int'(dac_code), 12'h800);
      if (n == 2 * d)
        check(dac_code == ((v & 12'h800) | 12'h400), "R4 second trial",
              int'(dac_code), int'((v & 12'h800) | 12'h400));
      if (n == 7 * d)
        check({res_hi, res_lo} == prev_res, "R9 result held", int'({res_hi, res_lo}), int'(prev_res));
    end
    start_set = 1'b0;
    clk_sel = sel;
    irq_clr = 1'b0;
    check(n == 14 * d, poke_start ? "R8 length" : (poke_sel ? "R11 length" : "R3 length"), n, 14 * d);
    check({res_hi, res_lo} == v, poke_start ? "R8 result" : "R4 result", int'({res_hi, res_lo}), int'(v));
    check(res_hi == v[11:4], "R5 high part", int'(res_hi), int'(v[11:4]));
    check(res_lo == v[3:0], "R5 low part", int'(res_lo), int'(v[3:0]));
    check(irq_flag == 1'b1, hold_clr ? "R7 set beats clear" : "R6 irq set", int'(irq_flag), 1);
    check(start_bit == 1'b0, "R6 start cleared", int'(start_bit), 0);
    prev_res = v;
  endtask

  task automatic t_irq_clear();
    repeat (3) @(negedge clk);
    check(irq_flag == 1'b1, "R7 irq sticky", int'(irq_flag), 1);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(irq_flag == 1'b0, "R7 irq cleared", int'(irq_flag), 0);
  endtask

  task automatic t_abort(input logic [1:0] sel, input logic [11:0] v, input int at);
    int d;
    d = div_of(sel);
    vin = v;
    clk_sel = sel;
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    repeat (at) @(negedge clk);
    check(start_bit == 1'b1, "R10 running before abort", int'(start_bit), 1);
    start_clr = 1'b1;
    start_set = 1'b1;
    @(negedge clk);
    start_clr = 1'b0;
    start_set = 1'b0;
    check(start_bit == 1'b0, "R10 aborted", int'(start_bit), 0);
    repeat (14 * d + 4) @(negedge clk);
    check({res_hi, res_lo} == prev_res, "R10 result kept", int'({res_hi, res_lo}), int'(prev_res));
    check(irq_flag == 1'b0, "R10 no irq", int'(irq_flag), 0);
    check(start_bit == 1'b0, "R10 stays idle", int'(start_bit), 0);
  endtask

  task automatic t_idle_priority();
    @(negedge clk);
    start_set = 1'b1;
    start_clr = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    start_clr = 1'b0;
    check(start_bit == 1'b0, "R10 clear wins when idle", int'(start_bit), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_convert(2'd0, 12'hABC, 1'b0, 1'b0, 1'b0);
    t_irq_clear();
    t_convert(2'd1, 12'h000, 1'b0, 1'b0, 1'b0);
    t_irq_clear();
    t_convert(2'd2, 12'hFFF, 1'b1, 1'b0, 1'b0);
    t_irq_clear();
    t_convert(2'd3, 12'h5A3, 1'b0, 1'b1, 1'b0);
    t_irq_clear();
    t_convert(2'd0, 12'h800, 1'b0, 1'b1, 1'b1);
    t_irq_clear();
    t_convert(2'd1, 12'h7FF, 1'b1, 1'b0, 1'b0);
    t_irq_clear();
    t_abort(2'd1, 12'h123, 100);
    t_abort(2'd0, 12'h456, 54);
    t_idle_priority();
    t_convert(2'd0, 12'h3C5, 1'b0, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule